// File: doc/BRIEF.md
# FIFO Fill-Level Flags with Programmable Offsets

This block tracks how many words a 512-deep FIFO holds and derives two status flags from that count. A half-full flag marks the upper half of the storage. A single combined near-boundary flag is high when the FIFO is close to empty or close to full. The two distances that set "close" are the low offset X and the high offset Y. The word count is kept inside the block as an occupancy counter. Accepted write and read strobes from the FIFO's port logic drive it. The counter saturates at both ends.

Both offsets can be set once after every reset, through an active-low program enable and the low eight bits of the write-side data bus. The first clock edge with the enable low loads the bus value into X and Y. If the enable stays low for a second consecutive edge, only Y is loaded again. After that the programming window is closed until the next reset. The window is also closed once the write side has reported its first word. While a programming edge is in progress, the block raises a write-inhibit output. The FIFO uses it to suppress data storage, and the block itself does not count the strobe.

Both flags are combinational decodes of the registered count and offsets. They therefore reflect a write, read or programming edge right after that edge.

Top module: `fifo_almost_flags`

## Requirements
- R1: While reset is asserted and right after it, half_o is 0, almost_o is 1, wr_block_o is 0 (with program enable high), and the word count is 0.
- R2: half_o is 1 when the count is 256 or more, and 0 when it is 255 or less.
- R3: almost_o is 1 when count <= X or count >= 512 - Y, and 0 otherwise.
- R4: The first rising edge after reset that sees prog_en_ni low loads data_i[7:0] into X and into Y.
- R5: If prog_en_ni is still low at the next rising edge, data_i[7:0] at that edge reloads Y only, and X keeps its value.
- R6: After the second programming edge, or after prog_en_ni returns high following the first one, further low levels on prog_en_ni change nothing until the next reset.
- R7: Once first_wr_i has been seen high, or a write has been counted, programming is ignored and wr_block_o stays 0.
- R8: wr_block_o is 1 exactly during a programming edge. A wr_i pulse on that edge does not change the count.
- R9: Without programming, X and Y are both 128.
- R10: Every reset returns X and Y to 128 and reopens the programming window.
- R11: A write at count 512 and a read at count 0 leave the count unchanged.
- R12: The offset range is 0 to 255. With X = Y = 255, count 256 gives almost_o = 0, and counts 255 and 257 give almost_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Write-side clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prog_en_ni | input | 1 | Active-low offset program enable |
| data_i | input | 8 | Low bits of the write data bus, used as the offset value |
| wr_i | input | 1 | Write strobe, counted unless inhibited or full |
| rd_i | input | 1 | Read strobe, counted unless empty |
| first_wr_i | input | 1 | High once the write side has stored a word |
| half_o | output | 1 | Count is at least half the depth |
| almost_o | output | 1 | Count is within X of empty or within Y of full |
| wr_block_o | output | 1 | Inhibits data storage during a programming edge |

## Verification
The bench sweeps the count through the whole range, from 0 up to 512 and back, under each offset setting. A flag that is off by one at 256, at X or at 512 - Y is therefore caught at the exact count where it goes wrong. The sequences include a single programming edge, two edges, three edges, programming after first_wr_i, and programming after a real write. A sequencer that lets a third edge through, reloads X on the second edge, or accepts offsets once the FIFO is in use ends up with flags that switch at the wrong counts. Writes at full and reads at empty are followed by a long walk of counted operations. A counter that wrapped would then place the flag transitions away from where the bench expects them.

// File: rtl/fifo_flag_pkg.sv
package fifo_flag_pkg;
  typedef enum logic [1:0] {
    PRG_ARMED  = 2'd0,
    PRG_SECOND = 2'd1,
    PRG_CLOSED = 2'd2
  } prg_state_e;
endpackage

// File: rtl/flag_prog_seq.sv
module flag_prog_seq
  import fifo_flag_pkg::*;
#(
  parameter int OFFS_W   = 8,
  parameter int DEF_OFFS = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_en_ni,
  input  logic [OFFS_W-1:0] data_i,
  input  logic              first_wr_i,
  input  logic              wr_i,
  output logic [OFFS_W-1:0] x_o,
  output logic [OFFS_W-1:0] y_o,
  output logic              wr_block_o
);
  localparam logic [OFFS_W-1:0] DEF_V = OFFS_W'(DEF_OFFS);

  prg_state_e        state_q;
  logic              seen_q;
  logic [OFFS_W-1:0] x_q, y_q;
  logic              lock_now, prog_edge;

  assign lock_now   = seen_q | first_wr_i;
  assign prog_edge  = !prog_en_ni && (state_q != PRG_CLOSED) && !lock_now;
  assign wr_block_o = prog_edge;
  assign x_o = x_q;
  assign y_o = y_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PRG_ARMED;
      seen_q  <= 1'b0;
      x_q     <= DEF_V;
      y_q     <= DEF_V;
    end else begin
      if (first_wr_i || (wr_i && !prog_edge)) seen_q <= 1'b1;
      unique case (state_q)
        PRG_ARMED: if (prog_edge) begin
          x_q     <= data_i;
          y_q     <= data_i;
          state_q <= PRG_SECOND;
        end
        PRG_SECOND: begin
          if (prog_edge) y_q <= data_i;
          // window closes on the second edge or when the enable is released
          state_q <= PRG_CLOSED;
        end
        default: state_q <= PRG_CLOSED;
      endcase
    end
  end

  a_r5_y_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PRG_SECOND) |=> $stable(x_q));
  a_r6_closed_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PRG_CLOSED) |=> ($stable(x_q) && $stable(y_q) && state_q == PRG_CLOSED));
  a_r7_lock_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |=> ($stable(x_q) && $stable(y_q)));
  a_r8_block_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_block_o |=> (state_q != PRG_ARMED));
endmodule

// File: rtl/flag_occ_cnt.sv
module flag_occ_cnt #(
  parameter int DEPTH = 512,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] FULL_V = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q;
  logic inc, dec;

  assign inc   = wr_i && (cnt_q != FULL_V);
  assign dec   = rd_i && (cnt_q != '0);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (inc && !dec) cnt_q <= cnt_q + 1'b1;
    else if (dec && !inc) cnt_q <= cnt_q - 1'b1;
  end

  a_r11_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_V);
  a_r11_full_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == FULL_V && !rd_i) |=> (cnt_q == FULL_V));
endmodule

// File: rtl/flag_cmp.sv
module flag_cmp #(
  parameter int DEPTH  = 512,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int OFFS_W = 8
) (
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [OFFS_W-1:0] x_i,
  input  logic [OFFS_W-1:0] y_i,
  output logic              half_o,
  output logic              almost_o
);
  localparam logic [CNT_W-1:0] FULL_V = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_V = CNT_W'(DEPTH / 2);

  logic [CNT_W-1:0] hi_thr;
  logic near_lo, near_hi;

  assign hi_thr   = FULL_V - CNT_W'(y_i);
  assign near_lo  = cnt_i <= CNT_W'(x_i);
  assign near_hi  = cnt_i >= hi_thr;
  assign half_o   = cnt_i >= HALF_V;
  assign almost_o = near_lo || near_hi;
endmodule

// File: rtl/fifo_almost_flags.sv
module fifo_almost_flags #(
  parameter int DEPTH    = 512,
  parameter int OFFS_W   = 8,
  parameter int DEF_OFFS = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_en_ni,
  input  logic [OFFS_W-1:0] data_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              first_wr_i,
  output logic              half_o,
  output logic              almost_o,
  output logic              wr_block_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] HALF_V = CNT_W'(DEPTH / 2);

  logic [OFFS_W-1:0] x_w, y_w;
  logic [CNT_W-1:0]  cnt_w;
  logic              block_w;

  flag_prog_seq #(.OFFS_W(OFFS_W), .DEF_OFFS(DEF_OFFS)) u_seq (
    .clk_i, .rst_ni, .prog_en_ni, .data_i, .first_wr_i, .wr_i,
    .x_o(x_w), .y_o(y_w), .wr_block_o(block_w)
  );

  flag_occ_cnt #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .wr_i(wr_i && !block_w), .rd_i, .cnt_o(cnt_w)
  );

  flag_cmp #(.DEPTH(DEPTH), .CNT_W(CNT_W), .OFFS_W(OFFS_W)) u_cmp (
    .cnt_i(cnt_w), .x_i(x_w), .y_i(y_w), .half_o, .almost_o
  );

  assign wr_block_o = block_w;

  a_r3_empty_almost: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_w == '0) |-> almost_o);
  a_r2_half_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(half_o) |-> ($past(cnt_w) == HALF_V - 1'b1));
  a_r8_blocked_no_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (block_w && !rd_i) |=> (cnt_w == $past(cnt_w)));
endmodule

// File: tb/fifo_almost_flags_bench.sv
module fifo_almost_flags_bench;
  localparam int CLK_NS = 20;

  logic clk = 0, rst_ni = 0, prog_en_ni = 1, wr_i = 0, rd_i = 0, first_wr_i = 0;
  logic [7:0] data_i = '0;
  logic half_o, almost_o, wr_block_o;

  int checks = 0, errors = 0;
  int mx, my, mc, pstate;
  bit locked;

  always #(CLK_NS/2) clk = ~clk;

  fifo_almost_flags u_fifo_almost_flags (
    .clk_i(clk), .rst_ni, .prog_en_ni, .data_i, .wr_i, .rd_i, .first_wr_i,
    .half_o, .almost_o, .wr_block_o
  );

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b (count %0d X %0d Y %0d)", req, act, exp, mc, mx, my);
    end
  endtask

  task automatic chk_flags();
    chk("R2 half", half_o, mc >= 256);
    chk("R3 almost", almost_o, (mc <= mx) || (mc >= 512 - my));
  endtask

  task automatic cyc(bit w, bit r);
    int nc;
    wr_i = w; rd_i = r;
    nc = mc;
    if (w && mc < 512) nc++;
    if (r && mc > 0) nc--;
    if (w && !r && mc < 512) locked = 1;
    @(negedge clk);
    wr_i = 0; rd_i = 0;
    mc = nc;
    chk_flags();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0; prog_en_ni = 1; first_wr_i = 0;
    mx = 128; my = 128; mc = 0; pstate = 0; locked = 0;
    #1;
    chk("R1 half in reset", half_o, 1'b0);
    chk("R1 almost in reset", almost_o, 1'b1);
    @(negedge clk); @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 half after reset", half_o, 1'b0);
    chk("R1 almost after reset", almost_o, 1'b1);
    chk("R1 block after reset", wr_block_o, 1'b0);
  endtask

  // one program-enable edge with a write strobe on it
  task automatic prog_edge(logic [7:0] d);
    bit open;
    open = (pstate != 2) && !locked;
    prog_en_ni = 0; data_i = d; wr_i = 1;
    #1;
    chk(open ? "R8 block during programming" : "R7 no block when closed", wr_block_o, open);
    @(negedge clk);
    wr_i = 0;
    if (open) begin
      if (pstate == 0) begin mx = d; my = d; pstate = 1; end
      else begin my = d; pstate = 2; end
    end else begin
      if (mc < 512) mc++;
      locked = 1;
    end
    chk_flags();
  endtask

  task automatic prog_release();
    prog_en_ni = 1;
    @(negedge clk);
    if (pstate == 1) pstate = 2;
    chk_flags();
  endtask

  // full-range walk with saturation probes at both ends (R11)
  task automatic sweep();
    while (mc > 0) cyc(0, 1);
    cyc(0, 1);
    chk("R11 empty hold", almost_o, 1'b1);
    while (mc < 512) cyc(1, 0);
    cyc(1, 0);
    while (mc > 0) cyc(0, 1);
  endtask

  task automatic t_defaults();
    do_reset();
    sweep(); // R9: defaults 128/128
  endtask

  task automatic t_one_edge();
    do_reset();
    prog_edge(8'd10); // R4
    prog_release();
    prog_edge(8'd99); // R6: ignored after release
    prog_release();
    sweep();
  endtask

  task automatic t_two_edges();
    do_reset();
    prog_edge(8'd20);
    prog_edge(8'd40); // R5
    prog_release();
    sweep();
  endtask

  task automatic t_three_edges();
    do_reset();
    prog_edge(8'd20);
    prog_edge(8'd40);
    prog_edge(8'd70); // R6: third edge ignored
    prog_release();
    sweep();
  endtask

  task automatic t_lock_first_wr();
    do_reset();
    first_wr_i = 1; @(negedge clk); first_wr_i = 0; locked = 1;
    prog_edge(8'd5); // R7
    prog_release();
    sweep();
  endtask

  task automatic t_lock_write();
    do_reset();
    cyc(1, 0);
    prog_edge(8'd5); // R7
    prog_release();
    sweep();
  endtask

  task automatic t_reprogram_reset();
    do_reset();
    prog_edge(8'd3);
    prog_release();
    do_reset(); // R10
    sweep();
  endtask

  task automatic t_max();
    do_reset();
    prog_edge(8'd255); // R12
    prog_release();
    while (mc < 255) cyc(1, 0);
    chk("R12 almost at 255", almost_o, 1'b1);
    cyc(1, 0);
    chk("R12 almost at 256", almost_o, 1'b0);
    cyc(1, 0);
    chk("R12 almost at 257", almost_o, 1'b1);
    sweep();
  endtask

  initial begin
    #(CLK_NS * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_defaults();
    t_one_edge();
    t_two_edges();
    t_three_edges();
    t_lock_first_wr();
    t_lock_write();
    t_reprogram_reset();
    t_max();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule